// File: doc/BRIEF.md
# MII Transmit Nibble Serializer

This block sits between a MAC-side byte source and the 4-bit transmit side of a media-independent PHY link. The source presents bytes on a valid/ready handshake, each tagged with start-of-frame, end-of-frame and an error request. When a start-of-frame byte is taken while the line is idle, the block emits the preamble and start frame delimiter. It then sends every payload byte as two nibbles, low half first, one nibble per transmit clock. The byte stream is expected to already carry headers and the frame check sequence.

The block owns the transmit error line. Within a frame it raises the line for a byte the source has flagged, or for the remainder of a frame whose source ran dry mid-frame, so that the receiver discards the frame. Outside a frame, with the enable line low, it can put a special-purpose signalling code on the data lines with the error line raised. Between frames it enforces a minimum idle gap.

Top module: `mii_tx_serializer`

## Requirements
- R1: While reset is active and in the first cycle after it, txEn, txEr and txd are all 0 and inReady is 1.
- R2: In the cycle after a byte with inSof is accepted while idle, txEn rises. The first PRE_NIBBLES-1 (15) nibbles are 0x5 and the next is 0xD, with inReady low throughout.
- R3: After the delimiter, each accepted byte is sent as bits [3:0] and then bits [7:4] on consecutive cycles. txEn stays high without a break until the high nibble of the byte marked inEof, and falls in the following cycle.
- R4: Within a frame, inReady is low during every preamble and delimiter nibble and during every high-nibble cycle. During a low-nibble cycle it is high unless that byte carries inEof.
- R5: A byte accepted with inErr set is sent with txEr high on both of its nibbles. The other nibbles of a frame with no underflow carry txEr low.
- R6: Underflow happens when, in a low-nibble cycle, inReady is high and inValid is low. The high nibble of that byte then goes out with txEr high, and txEn falls in the cycle after it. Bytes that arrive later without inSof belong to no frame.
- R7: After txEn falls, it stays low for at least GAP_NIBBLES (24) cycles, and inReady is low for the first GAP_NIBBLES of those cycles.
- R8: While idle, a byte without inSof is accepted (inReady high) and dropped, and no frame follows it.
- R9: While idle, one cycle after sigReq is sampled high, txEn is 0, txEr is 1 and txd equals the sigCode sampled in that same cycle. One cycle after sigReq is released, txEr and txd return to 0. During a frame, sigReq has no effect on txEr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Source byte valid |
| inReady | output | 1 | Block accepts a byte at this edge |
| inData | input | 2*NIB_W | Source byte |
| inSof | input | 1 | Byte starts a frame |
| inEof | input | 1 | Byte ends a frame |
| inErr | input | 1 | Request that this byte be sent corrupted |
| sigReq | input | 1 | Request out-of-frame signalling |
| sigCode | input | NIB_W | Signalling code for the data lines |
| txd | output | NIB_W | Transmit nibble |
| txEn | output | 1 | Transmit enable |
| txEr | output | 1 | Transmit error |

## Verification
The first preamble nibble is due in the cycle right after the edge that takes a start byte. Body nibbles follow the delimiter back to back, and a signalling code shows up one cycle after its request. The bench drives inputs after the falling edge and samples every output at the falling edge, so each value is read once its register has settled. A monitor records each frame from the rise of txEn to its fall and compares it with the nibble sequence that the driver computed from the bytes it sent. This includes the forced error nibble of a truncated frame. The gap length and the ready level in each preamble, high-nibble and gap cycle are counted per cycle. The signalling checks sample at fixed one-cycle offsets from the request edge.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_LO,
    ST_HI,
    ST_GAP
  } txState_e;

  typedef enum logic [2:0] {
    SEL_QUIET,
    SEL_PRE,
    SEL_SFD,
    SEL_LO,
    SEL_HI
  } nibSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadHeld;  // capture input byte as the one on the wire next
    logic    loadPend;  // capture input byte as the following one
    logic    movePend;  // promote pending byte to held byte
    logic    setAbort;  // underflow seen in a low-nibble cycle
    logic    clrAbort;  // frame over
    logic    idleSig;   // line idle, signalling codes allowed
    nibSel_e sel;       // which nibble source drives the line
  } txStrobe_t;

endpackage

// File: rtl/mii_tx_ctrl.sv
module mii_tx_ctrl
  import mii_tx_pkg::*;
#(
  parameter int PRE_NIBBLES = 16,
  parameter int GAP_NIBBLES = 24
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inSof,
  input  logic      heldEof,
  input  logic      abortFlag,
  output logic      inReady,
  output txStrobe_t strobe
);

  localparam int PRE_CW = $clog2(PRE_NIBBLES);
  localparam int GAP_CW = $clog2(GAP_NIBBLES);
  localparam logic [PRE_CW-1:0] PRE_LAST = PRE_CW'(PRE_NIBBLES - 1);
  localparam logic [GAP_CW-1:0] GAP_LAST = GAP_CW'(GAP_NIBBLES - 1);

  txState_e          state;
  txState_e          stateNext;
  logic [PRE_CW-1:0] preCnt;
  logic [GAP_CW-1:0] gapCnt;

  always_comb begin
    stateNext = state;
    inReady   = 1'b0;
    strobe    = '0;
    strobe.sel = SEL_QUIET;
    case (state)
      ST_IDLE: begin
        inReady        = 1'b1;
        strobe.idleSig = 1'b1;
        if (inValid && inSof) begin
          strobe.loadHeld = 1'b1;
          stateNext       = ST_PRE;
        end
      end
      ST_PRE: begin
        if (preCnt == PRE_LAST) begin
          strobe.sel = SEL_SFD;
          stateNext  = ST_LO;
        end else begin
          strobe.sel = SEL_PRE;
        end
      end
      ST_LO: begin
        strobe.sel = SEL_LO;
        inReady    = !heldEof;
        if (!heldEof) begin
          if (inValid) strobe.loadPend = 1'b1;
          else         strobe.setAbort = 1'b1;
        end
        stateNext = ST_HI;
      end
      ST_HI: begin
        strobe.sel = SEL_HI;
        if (heldEof || abortFlag) begin
          strobe.clrAbort = 1'b1;
          stateNext       = ST_GAP;
        end else begin
          strobe.movePend = 1'b1;
          stateNext       = ST_LO;
        end
      end
      ST_GAP: begin
        if (gapCnt == GAP_LAST) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      preCnt <= '0;
      gapCnt <= '0;
    end else begin
      state  <= stateNext;
      preCnt <= (state == ST_PRE) ? preCnt + 1'b1 : '0;
      gapCnt <= (state == ST_GAP) ? gapCnt + 1'b1 : '0;
    end
  end

endmodule

// File: rtl/mii_tx_datapath.sv
module mii_tx_datapath
  import mii_tx_pkg::*;
#(
  parameter int              NIB_W    = 4,
  parameter logic [NIB_W-1:0] PRE_CODE = 4'h5,
  parameter logic [NIB_W-1:0] SFD_CODE = 4'hD
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2*NIB_W-1:0] inData,
  input  logic               inEof,
  input  logic               inErr,
  input  logic               sigReq,
  input  logic [NIB_W-1:0]   sigCode,
  input  txStrobe_t          strobe,
  output logic               heldEof,
  output logic               abortFlag,
  output logic [NIB_W-1:0]   txd,
  output logic               txEn,
  output logic               txEr
);

  localparam int DATA_W = 2 * NIB_W;

  logic [DATA_W-1:0] heldByte;
  logic              heldErr;
  logic [DATA_W-1:0] pendByte;
  logic              pendEof;
  logic              pendErr;
  logic              sigOn;
  logic [NIB_W-1:0]  sigCodeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldByte  <= '0;
      heldEof   <= 1'b0;
      heldErr   <= 1'b0;
      pendByte  <= '0;
      pendEof   <= 1'b0;
      pendErr   <= 1'b0;
      abortFlag <= 1'b0;
      sigOn     <= 1'b0;
      sigCodeQ  <= '0;
    end else begin
      sigOn    <= sigReq;
      sigCodeQ <= sigCode;
      if (strobe.loadHeld) begin
        heldByte <= inData;
        heldEof  <= inEof;
        heldErr  <= inErr;
      end else if (strobe.movePend) begin
        heldByte <= pendByte;
        heldEof  <= pendEof;
        heldErr  <= pendErr;
      end
      if (strobe.loadPend) begin
        pendByte <= inData;
        pendEof  <= inEof;
        pendErr  <= inErr;
      end
      if (strobe.setAbort)      abortFlag <= 1'b1;
      else if (strobe.clrAbort) abortFlag <= 1'b0;
    end
  end

  always_comb begin
    txd  = '0;
    txEn = 1'b0;
    txEr = 1'b0;
    case (strobe.sel)
      SEL_PRE: begin
        txEn = 1'b1;
        txd  = PRE_CODE;
      end
      SEL_SFD: begin
        txEn = 1'b1;
        txd  = SFD_CODE;
      end
      SEL_LO: begin
        txEn = 1'b1;
        txd  = heldByte[NIB_W-1:0];
        txEr = heldErr;
      end
      SEL_HI: begin
        txEn = 1'b1;
        txd  = heldByte[DATA_W-1:NIB_W];
        txEr = heldErr | abortFlag;
      end
      default: begin
        if (strobe.idleSig && sigOn) begin
          txEr = 1'b1;
          txd  = sigCodeQ;
        end
      end
    endcase
  end

endmodule

// File: rtl/mii_tx_serializer.sv
module mii_tx_serializer
  import mii_tx_pkg::*;
#(
  parameter int               NIB_W       = 4,
  parameter int               PRE_NIBBLES = 16,
  parameter int               GAP_NIBBLES = 24,
  parameter logic [NIB_W-1:0] PRE_CODE    = 4'h5,
  parameter logic [NIB_W-1:0] SFD_CODE    = 4'hD
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [2*NIB_W-1:0] inData,
  input  logic               inSof,
  input  logic               inEof,
  input  logic               inErr,
  input  logic               sigReq,
  input  logic [NIB_W-1:0]   sigCode,
  output logic [NIB_W-1:0]   txd,
  output logic               txEn,
  output logic               txEr
);

  txStrobe_t strobe;
  logic      heldEof;
  logic      abortFlag;

  mii_tx_ctrl #(
    .PRE_NIBBLES(PRE_NIBBLES),
    .GAP_NIBBLES(GAP_NIBBLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inSof    (inSof),
    .heldEof  (heldEof),
    .abortFlag(abortFlag),
    .inReady  (inReady),
    .strobe   (strobe)
  );

  mii_tx_datapath #(
    .NIB_W   (NIB_W),
    .PRE_CODE(PRE_CODE),
    .SFD_CODE(SFD_CODE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inData   (inData),
    .inEof    (inEof),
    .inErr    (inErr),
    .sigReq   (sigReq),
    .sigCode  (sigCode),
    .strobe   (strobe),
    .heldEof  (heldEof),
    .abortFlag(abortFlag),
    .txd      (txd),
    .txEn     (txEn),
    .txEr     (txEr)
  );

endmodule

// File: rtl/mii_tx_checker.sv
module mii_tx_checker #(
  parameter int               NIB_W       = 4,
  parameter int               GAP_NIBBLES = 24,
  parameter logic [NIB_W-1:0] PRE_CODE    = 4'h5
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             inSof,
  input logic             sigReq,
  input logic [NIB_W-1:0] sigCode,
  input logic [NIB_W-1:0] txd,
  input logic             txEn,
  input logic             txEr
);

  localparam int LOW_CW = $clog2(GAP_NIBBLES + 1);
  localparam logic [LOW_CW-1:0] GAP_MIN = LOW_CW'(GAP_NIBBLES);

  // consecutive low cycles of txEn seen before the current cycle
  logic [LOW_CW-1:0] lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN)             lowCnt <= GAP_MIN;
    else if (txEn)         lowCnt <= '0;
    else if (lowCnt < GAP_MIN) lowCnt <= lowCnt + 1'b1;
  end

  a_r2_preamble_start: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSof && inReady && !txEn) |=> (txEn && txd == PRE_CODE && !inReady));

  a_r4_ready_low_at_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEn) |-> !inReady);

  a_r6_underflow_error: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && inReady && !inValid) |=> (txEn && txEr));

  a_r6_underflow_end: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && inReady && !inValid) |=> ##1 !txEn);

  a_r7_ready_low_at_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEn) |-> !inReady);

  a_r7_gap_length: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEn) |-> (lowCnt >= GAP_MIN));

  a_r9_signal_code: assert property (@(posedge clk) disable iff (!rstN)
    (txEr && !txEn) |-> ($past(sigReq) && txd == $past(sigCode)));

endmodule

bind mii_tx_serializer mii_tx_checker #(
  .NIB_W      (NIB_W),
  .GAP_NIBBLES(GAP_NIBBLES),
  .PRE_CODE   (PRE_CODE)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .inValid(inValid),
  .inReady(inReady),
  .inSof  (inSof),
  .sigReq (sigReq),
  .sigCode(sigCode),
  .txd    (txd),
  .txEn   (txEn),
  .txEr   (txEr)
);

// File: tb/mii_tx_serializer_tb.sv
`timescale 1ns/1ps
module mii_tx_serializer_tb;

  localparam int GAP = 24;
  localparam int PRE = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] inData = '0;
  logic       inSof = 1'b0;
  logic       inEof = 1'b0;
  logic       inErr = 1'b0;
  logic       sigReq = 1'b0;
  logic [3:0] sigCode = '0;
  logic [3:0] txd;
  logic       txEn;
  logic       txEr;

  always #10 clk = ~clk;

  mii_tx_serializer u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inSof(inSof), .inEof(inEof), .inErr(inErr),
    .sigReq(sigReq), .sigCode(sigCode), .txd(txd), .txEn(txEn), .txEr(txEr)
  );

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  bit    monOn = 0;
  logic [4:0] expQ[$];
  int    lenQ[$];
  string tagQ[$];
  logic [4:0] got[0:255];
  int    gotCnt = 0;
  int    lowRun = GAP;
  bit    prevEn = 0;
  bit    r4bad = 0;
  bit    gapBad = 0;

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic frameDone();
    int len;
    string tag;
    bit preOk;
    bit bodyOk;
    int preAct, preExp, bodyAct, bodyExp;
    logic [4:0] e;
    logic [4:0] g;
    preOk = 1; bodyOk = 1;
    preAct = 0; preExp = 0; bodyAct = 0; bodyExp = 0;
    if (lenQ.size() == 0) begin
      check(0, "R3 frame without a request", gotCnt, 0);
      return;
    end
    len = lenQ.pop_front();
    tag = tagQ.pop_front();
    for (int i = 0; i < len; i++) begin
      e = expQ.pop_front();
      g = (i < gotCnt && i < 256) ? got[i] : 5'h1f;
      if (g !== e) begin
        if (i < PRE && preOk) begin preOk = 0; preAct = g; preExp = e; end
        if (i >= PRE && bodyOk) begin bodyOk = 0; bodyAct = g; bodyExp = e; end
      end
    end
    check(gotCnt == len, {tag, " frame length in nibbles"}, gotCnt, len);
    check(preOk, "R2 preamble and delimiter {er,txd}", preAct, preExp);
    check(bodyOk, {tag, " body nibble {er,txd}"}, bodyAct, bodyExp);
    check(!r4bad, "R4 ready low in preamble and high-nibble cycles", r4bad, 0);
  endtask

  // monitor: samples at the falling edge
  always @(negedge clk) begin
    if (monOn) begin
      if (txEn) begin
        if (!prevEn) begin
          check(lowRun >= GAP && !gapBad, "R7 idle gap before frame / ready in gap", lowRun, GAP);
          r4bad = 0;
          gapBad = 0;
          gotCnt = 0;
        end
        if (inReady && (gotCnt < PRE || ((gotCnt - PRE) % 2 == 1))) r4bad = 1;
        if (gotCnt < 256) got[gotCnt] = {txEr, txd};
        gotCnt++;
        lowRun = 0;
      end else begin
        if (prevEn) frameDone();
        if (lowRun < GAP) begin
          if (inReady) gapBad = 1;
          lowRun++;
        end
      end
      prevEn = txEn;
    end
  end

  task automatic sendByte(input logic [7:0] d, input bit s, input bit e, input bit er);
    @(negedge clk);
    inValid = 1; inData = d; inSof = s; inEof = e; inErr = er;
    #2;
    while (!inReady) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1;
    inValid = 0; inSof = 0; inEof = 0; inErr = 0;
  endtask

  // trunc < 0: complete frame; otherwise the source stops after byte trunc
  task automatic sendFrame(input int len, input int trunc, input string tagIn);
    logic [7:0] bytes[0:63];
    bit errs[0:63];
    int nb;
    bit anyErr;
    bit last;
    string tag;
    nb = (trunc >= 0) ? trunc + 1 : len;
    anyErr = 0;
    for (int b = 0; b < nb; b++) begin
      bytes[b] = 8'($urandom);
      errs[b] = ($urandom % 16 == 0);
      anyErr |= errs[b];
    end
    if (tagIn != "") tag = tagIn;
    else if (trunc >= 0) tag = "R6";
    else if (anyErr) tag = "R5";
    else tag = "R3";
    lenQ.push_back(PRE + 2 * nb);
    tagQ.push_back(tag);
    for (int p = 0; p < PRE - 1; p++) expQ.push_back(5'h05);
    expQ.push_back(5'h0d);
    for (int b = 0; b < nb; b++) begin
      last = (b == nb - 1);
      expQ.push_back({errs[b], bytes[b][3:0]});
      expQ.push_back({errs[b] | (last && trunc >= 0), bytes[b][7:4]});
    end
    for (int b = 0; b < nb; b++) begin
      last = (b == nb - 1);
      sendByte(bytes[b], b == 0, last && trunc < 0, errs[b]);
    end
    if (trunc >= 0) begin
      @(negedge clk);
      while (txEn) @(negedge clk);
    end
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (txEn || lenQ.size() != 0) @(negedge clk);
    repeat (GAP + 6) @(negedge clk);
  endtask

  initial begin
    int seedInit;
    int len;
    int trunc;
    bit sawEn;
    seedInit = $urandom(32'd20240917);
    repeat (3) @(negedge clk);
    check(txEn == 0 && txEr == 0 && txd == 0, "R1 outputs during reset", {txEn, txEr, txd}, 0);
    rstN = 1;
    @(negedge clk);
    check(txEn == 0 && txEr == 0 && txd == 0, "R1 outputs after reset", {txEn, txEr, txd}, 0);
    check(inReady == 1, "R1 ready after reset", inReady, 1);
    monOn = 1;

    // directed corner cases
    sendFrame(1, -1, "R3");
    sendFrame(5, 0, "R6");
    sendFrame(4, 2, "R6");
    sendFrame(2, -1, "");
    waitIdle();

    // R8: byte without start flag while idle
    sendByte(8'hA7, 0, 1, 0);
    sawEn = 0;
    repeat (20) begin
      @(negedge clk);
      if (txEn) sawEn = 1;
    end
    check(!sawEn, "R8 no frame from byte without start flag", sawEn, 0);

    // R9: out-of-frame signalling
    @(negedge clk);
    sigReq = 1; sigCode = 4'hE;
    @(negedge clk);
    check(txEr == 1 && txEn == 0 && txd == 4'hE, "R9 signalling code E", {txEn, txEr, txd}, 6'h0E | 6'h10);
    sigCode = 4'h3;
    @(negedge clk);
    check(txEr == 1 && txEn == 0 && txd == 4'h3, "R9 signalling code 3", {txEn, txEr, txd}, 6'h13);
    sigReq = 0;
    @(negedge clk);
    check(txEr == 0 && txd == 0, "R9 signalling released", {txEr, txd}, 0);

    // R9: request during a frame leaves txEr untouched
    sigCode = 4'hF;
    sigReq = 1;
    sendFrame(6, -1, "R9");
    sigReq = 0;
    waitIdle();

    // random frames back to back
    for (int f = 0; f < 30; f++) begin
      len = 1 + ($urandom % 20);
      trunc = ($urandom % 5 == 0) ? int'($urandom % len) : -1;
      sendFrame(len, trunc, "");
    end
    waitIdle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before the run ended");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule